// File: doc/BRIEF.md
# Windowed Command and Interrupt Controller

This block is the control front end of a network adapter. It has one 16-bit host port. A write to it is a command and a read from it returns status. Each command word packs a 5-bit opcode into bits 15..11 and an 11-bit argument into bits 10..0. Commands that take no argument ignore it.

The controller holds a small amount of state:

- the selected register window,
- an interrupt enable mask,
- a mask that forces status bits to read as zero,
- the receive address filter,
- receiver and transmitter enables,
- seven sticky event flags.

Event pulses from the datapath set the flags. Acknowledge commands clear them with a bit mask. The interrupt output is driven from the masked summary of the flags.

Every accepted command is also republished for one cycle on a strobe bus, together with its opcode and argument. Neighbouring units decode the operations that this block does not handle itself.

Top module: `cmdirq_ctrl`

## Requirements
- R1: After reset the status word reads 0x0000, `irq_o`, `rx_en_o`, `tx_en_o` and `cmd_valid_o` are low and `rx_filter_o` is 0.
- R2: Opcode 0x01 loads the window from argument bits 2..0; status bits 15..13 show the window from the cycle after the write.
- R3: `evt_i[k]` sets sticky flag k, shown at status bit k+1 (bit 1 failure, 2 TX done, 3 TX space, 4 RX done, 5 RX early, 6 interrupt requested, 7 statistics); a flag stays set until cleared.
- R4: Opcode 0x0D clears flag k for every argument bit k+1 that is set, for k = 0..6; argument bit 0 and bits 10..8 have no effect.
- R5: If an event pulse and an acknowledge for the same flag arrive in one cycle, the flag ends up set.
- R6: Opcode 0x0E loads the interrupt mask from argument bits 7..1. Status bit 0 (the latch) and `irq_o` are high exactly when some flag at status bit j has mask bit j set.
- R7: Opcode 0x0F loads an 8-bit mask from argument bits 7..0; each set bit forces the matching status bit 7..0 to read 0, without changing the flags or `irq_o`.
- R8: Opcode 0x10 loads `rx_filter_o` from argument bits 3..0 (bit 0 own address, 1 multicast, 2 broadcast, 3 all frames).
- R9: Opcode 0x0C sets the interrupt-requested flag (status bit 6).
- R10: Opcode 0x04 sets `rx_en_o`, while 0x03 and 0x05 clear it. Opcode 0x09 sets `tx_en_o`, while 0x0A and 0x0B clear it.
- R11: After a write of opcode 0x00, 0x05 or 0x0B, status bit 12 is high for BUSY_CYCLES cycles, starting in the cycle after the write. It is low at all other times.
- R12: Opcode 0x00 returns the window, both masks, the filter, the flags and both enables to their reset values.
- R13: Every write drives `cmd_valid_o` high for exactly the next cycle, with `cmd_op_o` and `cmd_arg_o` taken from the word. An opcode with no local function, such as 0x14, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Command write strobe |
| host_wdata | input | 16 | Command word: opcode and argument |
| host_rdata | output | 16 | Status word |
| evt_i | input | 7 | Event pulses, one per sticky flag |
| irq_o | output | 1 | Interrupt request |
| rx_en_o | output | 1 | Receiver enable |
| tx_en_o | output | 1 | Transmitter enable |
| rx_filter_o | output | 4 | Receive address filter |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 5 | Opcode of the strobed command |
| cmd_arg_o | output | 11 | Argument of the strobed command |

## Verification
Some rules are checked by assertions on every cycle:

- an event always wins over a same-cycle acknowledge,
- an acknowledge clears the flags it names,
- a reset-type command raises the busy bit,
- a window or filter write lands one cycle later,
- the strobe follows each write by exactly one cycle.

Other behaviour needs the bench scenarios:

- the composed status word under the read-zero mask,
- the exact length of the busy window,
- an acknowledge of bit 0 doing nothing,
- an unhandled opcode leaving all state intact.

// File: rtl/cmdirq_pkg.sv
package cmdirq_pkg;

    localparam int WORD_W = 16;
    localparam int OP_W   = 5;
    localparam int ARG_W  = WORD_W - OP_W;
    localparam int EVT_N  = 7;
    localparam int WIN_W  = 3;
    localparam int FILT_W = 4;

    localparam logic [OP_W-1:0] OP_GRESET  = 5'h00;
    localparam logic [OP_W-1:0] OP_WINDOW  = 5'h01;
    localparam logic [OP_W-1:0] OP_RX_OFF  = 5'h03;
    localparam logic [OP_W-1:0] OP_RX_ON   = 5'h04;
    localparam logic [OP_W-1:0] OP_RX_RST  = 5'h05;
    localparam logic [OP_W-1:0] OP_TX_ON   = 5'h09;
    localparam logic [OP_W-1:0] OP_TX_OFF  = 5'h0A;
    localparam logic [OP_W-1:0] OP_TX_RST  = 5'h0B;
    localparam logic [OP_W-1:0] OP_IRQ_REQ = 5'h0C;
    localparam logic [OP_W-1:0] OP_ACK     = 5'h0D;
    localparam logic [OP_W-1:0] OP_IMASK   = 5'h0E;
    localparam logic [OP_W-1:0] OP_ZMASK   = 5'h0F;
    localparam logic [OP_W-1:0] OP_FILTER  = 5'h10;

    // flag index of the interrupt-requested event
    localparam int IRQ_REQ_IDX = 5;

    typedef struct packed {
        logic greset;
        logic window;
        logic rx_off;
        logic rx_on;
        logic rx_rst;
        logic tx_on;
        logic tx_off;
        logic tx_rst;
        logic irq_req;
        logic ack;
        logic imask;
        logic zmask;
        logic filter;
    } dec_t;

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
    import cmdirq_pkg::*;
(
    input  logic              wr_i,
    input  logic [WORD_W-1:0] word_i,
    output dec_t              dec_o,
    output logic [OP_W-1:0]   op_o,
    output logic [ARG_W-1:0]  arg_o
);

    always_comb begin
        op_o  = word_i[WORD_W-1 -: OP_W];
        arg_o = word_i[ARG_W-1:0];
        dec_o = '0;
        if (wr_i) begin
            case (op_o)
                OP_GRESET:  dec_o.greset  = 1'b1;
                OP_WINDOW:  dec_o.window  = 1'b1;
                OP_RX_OFF:  dec_o.rx_off  = 1'b1;
                OP_RX_ON:   dec_o.rx_on   = 1'b1;
                OP_RX_RST:  dec_o.rx_rst  = 1'b1;
                OP_TX_ON:   dec_o.tx_on   = 1'b1;
                OP_TX_OFF:  dec_o.tx_off  = 1'b1;
                OP_TX_RST:  dec_o.tx_rst  = 1'b1;
                OP_IRQ_REQ: dec_o.irq_req = 1'b1;
                OP_ACK:     dec_o.ack     = 1'b1;
                OP_IMASK:   dec_o.imask   = 1'b1;
                OP_ZMASK:   dec_o.zmask   = 1'b1;
                OP_FILTER:  dec_o.filter  = 1'b1;
                default:    dec_o = '0;
            endcase
        end
    end

    // at most one operation is decoded from a word
    always_comb begin
        assert ($countones(dec_o) <= 1)
            else $error("p_single_decode_r13");
    end

endmodule

// File: rtl/evt_flags.sv
module evt_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    logic [N-1:0] flags_d, flags_q;

    always_comb begin
        // a set in the same cycle overrides a clear
        flags_d = (flags_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_o & $past(set_i)) == $past(set_i)));

    p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((flags_o & $past(clr_i & ~set_i)) == '0));

    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i == '0) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));

endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);

    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)           cnt_d = CW'(CYCLES);
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);

    p_busy_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> busy_o);

    p_busy_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !load_i) |=> !busy_o);

endmodule

// File: rtl/cmdirq_ctrl.sv
module cmdirq_ctrl
    import cmdirq_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic [EVT_N-1:0]  evt_i,
    output logic              irq_o,
    output logic              rx_en_o,
    output logic              tx_en_o,
    output logic [FILT_W-1:0] rx_filter_o,
    output logic              cmd_valid_o,
    output logic [OP_W-1:0]   cmd_op_o,
    output logic [ARG_W-1:0]  cmd_arg_o
);

    localparam int LOW_W = EVT_N + 1;
    localparam int PAD_W = WORD_W - WIN_W - 1 - LOW_W;

    typedef struct packed {
        logic [WIN_W-1:0]  win;
        logic [EVT_N-1:0]  imask;
        logic [LOW_W-1:0]  zmask;
        logic [FILT_W-1:0] filt;
        logic              rx_en;
        logic              tx_en;
        logic              stb_v;
        logic [OP_W-1:0]   stb_op;
        logic [ARG_W-1:0]  stb_arg;
    } st_t;

    st_t              s_d, s_q;
    dec_t             dec;
    logic [OP_W-1:0]  op;
    logic [ARG_W-1:0] arg;
    logic [EVT_N-1:0] flags, fset, fclr;
    logic             busy, latch;
    logic [LOW_W-1:0] low_raw;

    cmd_decode u_dec (
        .wr_i   (host_wr),
        .word_i (host_wdata),
        .dec_o  (dec),
        .op_o   (op),
        .arg_o  (arg)
    );

    always_comb begin
        fset = evt_i;
        fset[IRQ_REQ_IDX] = evt_i[IRQ_REQ_IDX] | dec.irq_req;
        fclr = '0;
        if (dec.ack)    fclr = arg[EVT_N:1];
        if (dec.greset) fclr = '1;
    end

    evt_flags #(.N(EVT_N)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (fset),
        .clr_i   (fclr),
        .flags_o (flags)
    );

    busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (dec.greset | dec.rx_rst | dec.tx_rst),
        .busy_o (busy)
    );

    always_comb begin
        s_d = s_q;
        s_d.stb_v   = host_wr;
        s_d.stb_op  = op;
        s_d.stb_arg = arg;
        if (dec.window) s_d.win   = arg[WIN_W-1:0];
        if (dec.imask)  s_d.imask = arg[EVT_N:1];
        if (dec.zmask)  s_d.zmask = arg[LOW_W-1:0];
        if (dec.filter) s_d.filt  = arg[FILT_W-1:0];
        if (dec.rx_on)                s_d.rx_en = 1'b1;
        if (dec.rx_off || dec.rx_rst) s_d.rx_en = 1'b0;
        if (dec.tx_on)                s_d.tx_en = 1'b1;
        if (dec.tx_off || dec.tx_rst) s_d.tx_en = 1'b0;
        if (dec.greset) begin
            s_d.win   = '0;
            s_d.imask = '0;
            s_d.zmask = '0;
            s_d.filt  = '0;
            s_d.rx_en = 1'b0;
            s_d.tx_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        latch      = |(flags & s_q.imask);
        low_raw    = {flags, latch} & ~s_q.zmask;
        host_rdata = {s_q.win, busy, {PAD_W{1'b0}}, low_raw};
    end

    assign irq_o       = latch;
    assign rx_en_o     = s_q.rx_en;
    assign tx_en_o     = s_q.tx_en;
    assign rx_filter_o = s_q.filt;
    assign cmd_valid_o = s_q.stb_v;
    assign cmd_op_o    = s_q.stb_op;
    assign cmd_arg_o   = s_q.stb_arg;

    p_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && op == OP_WINDOW) |=>
            (host_rdata[WORD_W-1 -: WIN_W] == $past(host_wdata[WIN_W-1:0])));

    p_strobe_r13: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (cmd_valid_o && cmd_op_o == $past(op)));

    p_strobe_once_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> !cmd_valid_o);

    p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> (flags != '0));

    p_rx_on_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && op == OP_RX_ON) |=> rx_en_o);

    p_filter_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && op == OP_FILTER) |=> (rx_filter_o == $past(host_wdata[FILT_W-1:0])));

    p_greset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && op == OP_GRESET) |=>
            (host_rdata[WORD_W-1 -: WIN_W] == '0 && rx_filter_o == '0 && !irq_o && !rx_en_o));

endmodule

// File: tb/sim_cmdirq_ctrl.sv
module sim_cmdirq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic [6:0]  evt_i = '0;
    logic        irq_o, rx_en_o, tx_en_o, cmd_valid_o;
    logic [3:0]  rx_filter_o;
    logic [4:0]  cmd_op_o;
    logic [10:0] cmd_arg_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    cmdirq_ctrl #(.BUSY_CYCLES(8)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .evt_i(evt_i), .irq_o(irq_o), .rx_en_o(rx_en_o),
        .tx_en_o(tx_en_o), .rx_filter_o(rx_filter_o), .cmd_valid_o(cmd_valid_o),
        .cmd_op_o(cmd_op_o), .cmd_arg_o(cmd_arg_o)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] word;
        logic [6:0]  ev;
        logic [15:0] st;
        logic        irq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 16'h0805, 7'h00, 16'hA000, 1'b0}, // R2 window 5
        '{1'b0, 16'h0000, 7'h02, 16'hA004, 1'b0}, // R3 TX done event
        '{1'b1, 16'h7004, 7'h00, 16'hA005, 1'b1}, // R6 mask bit 2
        '{1'b1, 16'h6804, 7'h10, 16'hA020, 1'b0}, // R4 ack bit 2, RX early event
        '{1'b1, 16'h6820, 7'h10, 16'hA020, 1'b0}, // R5 set wins
        '{1'b1, 16'h6000, 7'h00, 16'hA060, 1'b0}, // R9 request
        '{1'b1, 16'h7040, 7'h00, 16'hA061, 1'b1}, // R6 mask bit 6
        '{1'b1, 16'h7841, 7'h00, 16'hA020, 1'b1}, // R7 read-zero bits 0,6
        '{1'b1, 16'h6FFF, 7'h00, 16'hA000, 1'b0}, // R4 ack all
        '{1'b1, 16'hA123, 7'h00, 16'hA000, 1'b0}, // R13 unhandled opcode
        '{1'b1, 16'h0FFF, 7'h00, 16'hE000, 1'b0}, // R2 window 7 from wide argument
        '{1'b0, 16'h0000, 7'h7F, 16'hE0BE, 1'b1}  // R3 R7 all events under mask
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit wr, input logic [15:0] word, input logic [6:0] ev);
        @(negedge clk);
        host_wr    = wr;
        host_wdata = word;
        evt_i      = ev;
        @(posedge clk);
        #1;
        @(negedge clk);
        host_wr = 1'b0;
        evt_i   = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk(host_rdata == 16'h0000, "R1 status", host_rdata, 0);
        chk(!irq_o && !rx_en_o && !tx_en_o && !cmd_valid_o, "R1 outputs",
            {irq_o, rx_en_o, tx_en_o, cmd_valid_o}, 0);
        chk(rx_filter_o == 4'h0, "R1 filter", rx_filter_o, 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            host_wr    = TBL[i].wr;
            host_wdata = TBL[i].word;
            evt_i      = TBL[i].ev;
            @(posedge clk);
            #1;
            chk(host_rdata == TBL[i].st, "R2-table status", host_rdata, TBL[i].st);
            chk(irq_o == TBL[i].irq, "R6 table irq", irq_o, TBL[i].irq);
            chk(cmd_valid_o == TBL[i].wr, "R13 table strobe", cmd_valid_o, TBL[i].wr);
        end
        @(negedge clk);
        host_wr = 1'b0;
        evt_i   = '0;

        // R4: acknowledge argument bit 0 leaves the flags intact
        step(1'b1, 16'h6801, 7'h00);
        chk(host_rdata == 16'hE0BE, "R4 ack bit0", host_rdata, 16'hE0BE);
        // R7: clearing the read-zero mask exposes the latch and bit 6
        step(1'b1, 16'h7800, 7'h00);
        chk(host_rdata == 16'hE0FF, "R7 unmask", host_rdata, 16'hE0FF);

        // R13 strobe content, then one cycle only, no state change
        @(negedge clk);
        host_wr = 1'b1; host_wdata = 16'hA123;
        @(posedge clk); #1;
        chk(cmd_valid_o && cmd_op_o == 5'h14, "R13 op", cmd_op_o, 5'h14);
        chk(cmd_arg_o == 11'h123, "R13 arg", cmd_arg_o, 11'h123);
        @(negedge clk);
        host_wr = 1'b0;
        @(posedge clk); #1;
        chk(!cmd_valid_o, "R13 single cycle", cmd_valid_o, 0);
        chk(host_rdata == 16'hE0FF, "R13 no state change", host_rdata, 16'hE0FF);

        // R8 filter
        step(1'b1, 16'h8005, 7'h00);
        chk(rx_filter_o == 4'h5, "R8 filter 5", rx_filter_o, 5);
        step(1'b1, 16'h87FA, 7'h00);
        chk(rx_filter_o == 4'hA, "R8 filter A", rx_filter_o, 4'hA);

        // R10 receiver
        step(1'b1, 16'h2000, 7'h00);
        chk(rx_en_o, "R10 rx on", rx_en_o, 1);
        step(1'b1, 16'h1800, 7'h00);
        chk(!rx_en_o, "R10 rx off", rx_en_o, 0);
        step(1'b1, 16'h2000, 7'h00);

        // R11 busy window after RX reset
        @(negedge clk);
        host_wr = 1'b1; host_wdata = 16'h2800;
        @(posedge clk); #1;
        chk(!rx_en_o, "R10 rx reset", rx_en_o, 0);
        chk(host_rdata[12], "R11 busy j0", host_rdata[12], 1);
        @(negedge clk);
        host_wr = 1'b0;
        for (int j = 1; j <= 8; j++) begin
            @(posedge clk); #1;
            if (j < 8) chk(host_rdata[12], "R11 busy held", j, 1);
            else       chk(!host_rdata[12], "R11 busy ended", host_rdata[12], 0);
        end

        // R10 transmitter
        step(1'b1, 16'h4800, 7'h00);
        chk(tx_en_o, "R10 tx on", tx_en_o, 1);
        step(1'b1, 16'h5000, 7'h00);
        chk(!tx_en_o, "R10 tx off", tx_en_o, 0);
        step(1'b1, 16'h4800, 7'h00);
        step(1'b1, 16'h5800, 7'h00);
        chk(!tx_en_o && host_rdata[12], "R10 R11 tx reset", {tx_en_o, host_rdata[12]}, 1);

        // R12 global reset
        step(1'b1, 16'h2000, 7'h00);
        step(1'b1, 16'h0000, 7'h00);
        chk(host_rdata == 16'h1000, "R12 status", host_rdata, 16'h1000);
        chk(!irq_o && !rx_en_o && !tx_en_o && rx_filter_o == 0, "R12 outputs",
            {irq_o, rx_en_o, tx_en_o, rx_filter_o}, 0);
        step(1'b0, 16'h0000, 7'h04);
        chk(host_rdata[7:0] == 8'h08 && !irq_o, "R12 mask cleared", host_rdata[7:0], 8'h08);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule